// File: doc/BRIEF.md
# Serial Exponential-Decay Synaptic Current Accumulator

This block works out the total input current that one model neuron receives from a large set of synapses in each model time step. Every synapse has a current trace. In each step the trace shrinks by a fixed fraction. If that synapse's input fired in the step, the synapse's weight is added to the trace. The block visits the synapses one after another and uses a single shared multiply-and-add path for all of them. It adds every updated trace into a wide sum and reports that sum when the sweep ends.

To start a sweep, the controller raises `start` for one cycle and at the same time presents the spike bits for the step and the decay factor. The weights are held outside the block. The block reads them through a synchronous read port with a latency of one cycle. The traces are held in a memory inside the block and carry over from one sweep to the next. Each synapse takes two cycles, so a sweep of N synapses finishes 2N+1 cycles after the start edge.

Top module: `syn_current_acc`

## Requirements
- R1: After reset, `done` is 0, `current` is 0 and every trace is 0. A sweep with no spikes then reports a current of 0.
- R2: For each synapse, the new trace is floor(trace·decay / 2^DEC_W), plus the signed weight if the synapse's spike bit is 1 (otherwise plus 0). Here `decay` is an unsigned fraction with DEC_W fractional bits, and the weight is a signed value of W_W bits.
- R3: The new trace is clamped to the signed range of T_W bits, from −2^(T_W−1) to 2^(T_W−1)−1.
- R4: `current` equals the exact sum of all N updated traces of the sweep. It is signed and wide enough that it cannot overflow.
- R5: The synapses are processed in index order, two cycles each. Synapse i appears on `w_addr` in the cycles after rising edges 2i and 2i+1, counted from the edge that accepts `start` (edge 0). The weight must be on `w_data` one cycle after its address.
- R6: `done` is high for exactly one cycle, after rising edge 2N+1. From that point `current` holds the result until the next accepted start.
- R7: An accepted start sets `current` to 0 on that same edge.
- R8: The spike vector and the decay factor are captured at the accepted start. Changes to them during a sweep have no effect on that sweep.
- R9: A `start` that arrives while a sweep is running is ignored. It does not shift the timing of `done` and does not change the result.
- R10: Traces carry over between sweeps, so each sweep decays the values left by the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a sweep when the block is idle |
| decay | input | DEC_W | Decay fraction, value / 2^DEC_W |
| spikes | input | N_SYN | One spike bit per synapse for this step |
| w_addr | output | $clog2(N_SYN) | Weight memory read address |
| w_data | input | W_W | Signed weight, one cycle after its address |
| current | output | ACC_W | Signed summed current |
| done | output | 1 | One-cycle pulse when `current` is final |

## Verification
The result is due 2N+1 rising edges after the edge that accepts the start. The bench counts those edges one by one. It checks that `done` is still low after edge 2N, that it is high with the expected sum after edge 2N+1, and that it is low again one edge later. The address checks are taken after edges 0 and 2, when synapses 0 and 1 should be on `w_addr`. The clearing of `current` is checked after edge 0. Every sample is taken 1 ns after a rising edge, so the block's registers and the bench's weight memory have both settled.

// File: rtl/syn_current_acc.sv
module syn_current_acc #(
  parameter int N_SYN = 500,
  parameter int W_W   = 16,
  parameter int T_W   = 24,
  parameter int DEC_W = 16,
  localparam int IDX_W = $clog2(N_SYN),
  localparam int ACC_W = T_W + $clog2(N_SYN) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [DEC_W-1:0]        decay,
  input  logic [N_SYN-1:0]        spikes,
  output logic [IDX_W-1:0]        w_addr,
  input  logic signed [W_W-1:0]   w_data,
  output logic signed [ACC_W-1:0] current,
  output logic                    done
);
  localparam int PW = T_W + DEC_W + 1;
  localparam logic signed [PW-1:0] MAXV = {{(DEC_W+2){1'b0}}, {(T_W-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = {{(DEC_W+2){1'b1}}, {(T_W-1){1'b0}}};
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_SYN - 1);

  logic                    busy, phase;
  logic [IDX_W-1:0]        idx;
  logic [N_SYN-1:0]        spk_r;
  logic [DEC_W-1:0]        dec_r;
  logic signed [T_W-1:0]   trace_mem [N_SYN];
  logic signed [T_W-1:0]   tr_q;
  logic                    spk_q;
  logic signed [T_W-1:0]   p_trace;
  logic                    p_valid, p_last;
  logic [IDX_W-1:0]        p_idx;
  logic signed [ACC_W-1:0] acc;

  logic signed [W_W-1:0] kick;
  logic signed [PW-1:0]  prod, sum_w;
  logic signed [T_W-1:0] sat;

  assign w_addr  = idx;
  assign current = acc;
  assign kick    = spk_q ? w_data : '0;

  always_comb begin
    prod  = tr_q * $signed({1'b0, dec_r});
    sum_w = (prod >>> DEC_W) + $signed({{(PW-W_W){kick[W_W-1]}}, kick});
    if (sum_w > MAXV)      sat = MAXV[T_W-1:0];
    else if (sum_w < MINV) sat = MINV[T_W-1:0];
    else                   sat = sum_w[T_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      phase   <= 1'b0;
      idx     <= '0;
      spk_r   <= '0;
      dec_r   <= '0;
      tr_q    <= '0;
      spk_q   <= 1'b0;
      p_trace <= '0;
      p_valid <= 1'b0;
      p_last  <= 1'b0;
      p_idx   <= '0;
      acc     <= '0;
      done    <= 1'b0;
      for (int i = 0; i < N_SYN; i++) trace_mem[i] <= '0;
    end else begin
      p_valid <= 1'b0;
      done    <= 1'b0;
      if (start && !busy) begin
        busy  <= 1'b1;
        phase <= 1'b0;
        idx   <= '0;
        acc   <= '0;
        spk_r <= spikes;
        dec_r <= decay;
      end else if (busy) begin
        if (!phase) begin
          tr_q  <= trace_mem[idx];
          spk_q <= spk_r[idx];
          phase <= 1'b1;
        end else begin
          p_trace <= sat;
          p_idx   <= idx;
          p_valid <= 1'b1;
          p_last  <= (idx == LAST);
          phase   <= 1'b0;
          if (idx != LAST) idx <= idx + 1'b1;
        end
      end
      if (p_valid) begin
        trace_mem[p_idx] <= p_trace;
        acc <= acc + ACC_W'(p_trace);
        if (p_last) begin
          done <= 1'b1;
          busy <= 1'b0;
        end
      end
    end
  end

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_clear_on_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (current == '0));
  assert_capture_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(p_valid && p_last)) |=> ($stable(spk_r) && $stable(dec_r)));
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(p_valid && p_last)) |=> busy);
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(current));
  assert_addr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (32'(w_addr) < N_SYN));
endmodule

// File: tb/tb_syn_current_acc.sv
`timescale 1ns/1ps
module tb_syn_current_acc;
  localparam int N     = 500;
  localparam int W_W   = 16;
  localparam int T_W   = 18;
  localparam int DEC_W = 16;
  localparam int IDX_W = $clog2(N);
  localparam int ACC_W = T_W + $clog2(N) + 1;
  localparam longint TMAX = (64'sd1 <<< (T_W-1)) - 1;
  localparam longint TMIN = -(64'sd1 <<< (T_W-1));

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [DEC_W-1:0] decay = '0;
  logic [N-1:0] spikes = '0;
  logic [IDX_W-1:0] w_addr;
  logic signed [W_W-1:0] w_data = '0;
  logic signed [ACC_W-1:0] current;
  logic done;

  logic signed [W_W-1:0] wmem [N];
  longint mtr [N];
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) w_data <= wmem[w_addr];

  syn_current_acc #(.N_SYN(N), .W_W(W_W), .T_W(T_W), .DEC_W(DEC_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .decay(decay), .spikes(spikes),
    .w_addr(w_addr), .w_data(w_data), .current(current), .done(done));

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint model(logic [N-1:0] sp, longint dec);
    longint sum = 0;
    for (int i = 0; i < N; i++) begin
      longint t = ((mtr[i] * dec) >>> DEC_W) + (sp[i] ? longint'(wmem[i]) : 0);
      if (t > TMAX) t = TMAX;
      if (t < TMIN) t = TMIN;
      mtr[i] = t;
      sum += t;
    end
    return sum;
  endfunction

  // One sweep; disturb=1 changes inputs and pulses start mid-sweep (R8, R9)
  task automatic run_pass(logic [N-1:0] sp, logic [DEC_W-1:0] dec, bit disturb, output longint got);
    longint exp;
    exp = model(sp, longint'(dec));
    @(negedge clk);
    spikes = sp; decay = dec; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk("R7 current cleared at start", longint'(current), 0);
    chk("R5 address of synapse 0", longint'(w_addr), 0);
    for (int k = 1; k <= 2*N; k++) begin
      @(posedge clk); #1;
      if (k == 2) chk("R5 address of synapse 1", longint'(w_addr), 1);
      if (disturb && k == 301) begin
        spikes = ~sp; decay = ~dec; start = 1'b1;
      end
      if (disturb && k == 302) start = 1'b0;
    end
    chk("R6 done low before edge 2N+1", longint'(done), 0);
    @(posedge clk); #1;
    chk("R6 done at edge 2N+1", longint'(done), 1);
    chk("R4 summed current", longint'(current), exp);
    got = longint'(current);
    @(posedge clk); #1;
    chk("R6 done is one cycle", longint'(done), 0);
    chk("R6 current held", longint'(current), exp);
  endtask

  function automatic logic [N-1:0] rnd_spikes();
    logic [N-1:0] s;
    for (int i = 0; i < N; i++) s[i] = 1'($urandom_range(0, 1));
    return s;
  endfunction

  task automatic rnd_weights();
    for (int i = 0; i < N; i++) wmem[i] = W_W'($urandom_range(0, 65535));
  endtask

  task automatic t_reset();
    longint got;
    chk("R1 done after reset", longint'(done), 0);
    chk("R1 current after reset", longint'(current), 0);
    rnd_weights();
    run_pass('0, 16'hFFFF, 1'b0, got);
    chk("R1 traces start at zero", got, 0);
  endtask

  task automatic t_kick_only();
    logic [N-1:0] sp;
    longint exp = 0, got;
    rnd_weights();
    sp = rnd_spikes();
    for (int i = 0; i < N; i++) if (sp[i]) exp += longint'(wmem[i]);
    run_pass(sp, '0, 1'b0, got);
    chk("R2 zero decay gives spiked weight sum", got, exp);
  endtask

  task automatic t_decay_random();
    longint got;
    for (int p = 0; p < 3; p++) begin
      rnd_weights();
      run_pass(rnd_spikes(), DEC_W'($urandom_range(0, 65535)), 1'b0, got);
    end
    for (int i = 0; i < N; i++) wmem[i] = '0;
    run_pass('0, 16'h8000, 1'b0, got); // R10 carried traces halve
  endtask

  task automatic t_ignore();
    longint got;
    rnd_weights();
    run_pass(rnd_spikes(), 16'hC000, 1'b1, got); // R8 R9 checked via R4/R6 checks
  endtask

  task automatic t_saturate();
    longint got;
    for (int i = 0; i < N; i++) mtr[i] = mtr[i];
    for (int i = 0; i < N; i++) wmem[i] = 16'sh7FFF;
    for (int p = 0; p < 6; p++) run_pass('1, 16'hFFFF, 1'b0, got);
    chk("R3 positive clamp", got, longint'(N) * TMAX);
    for (int i = 0; i < N; i++) wmem[i] = -16'sh8000;
    for (int p = 0; p < 9; p++) run_pass('1, 16'hFFFF, 1'b0, got);
    chk("R3 negative clamp", got, longint'(N) * TMIN);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin wmem[i] = '0; mtr[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_kick_only();
    t_decay_random();
    t_ignore();
    t_saturate();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule